// File: doc/BRIEF.md
# Class-Addressed Register File with Byte Combine

This block is the register storage of a small 16-bit core. It holds sixteen 16-bit registers. Each register is named by a 2-bit class code and a 2-bit index. Two read ports return stored values combinationally. Writes are applied on the falling clock edge. Because of this, the decode logic can read a register early in a cycle while the write-back from the same cycle lands half a cycle later.

Besides the general write port, there are two special paths:

- **Byte load:** places a zero-extended 8-bit immediate into one register of the staging class.
- **Combine:** joins the low bytes of staging registers p0 and p1 into one 16-bit word. This word is always presented as store data, next to the current content of a0, which serves as the store address. It can also be written back into any register in the same cycle.

One register, t1, is a hard zero. Reset loads a fixed set of starting values.

Top module: `regbank_top`

## Requirements
- R1: A register is selected by the 4-bit slot {class, index}. Class codes are v=00, t=01, a=10, p=11, and the index is 0..3. The bench relies on slot numbers v0..v3=0..3, t0=4, t1=5, a0=8, a1=9, p0=12, p1=13.
- R2: Both read ports return the stored content of their selected slot combinationally. The two ports are independent of each other.
- R3: Slot 5 (t1) always reads 0x0000 on both read ports.
- R4: A write of any kind (general, byte load, combine) aimed at slot 5 is ignored.
- R5: A general write with `wr_en` high stores `wr_data` into its slot on the falling clock edge of that cycle.
- R6: During the cycle of a write, a read of the written slot returns the value held before the write.
- R7: A byte load with `bl_en` high stores {8'h00, `bl_imm`} into slot {p, `bl_idx`}.
- R8: `st_word` always equals {p1[7:0], p0[7:0]}. The upper bytes of p0 and p1 have no effect on it.
- R9: With `cmb_en` high, the word that `st_word` shows before the edge is written into slot {`cmb_cls`, `cmb_idx`}.
- R10: `st_addr` always equals the current content of a0 (slot 8).
- R11: When several write sources target the same slot in one cycle, combine wins over byte load, and byte load wins over the general write.
- R12: Reset gives v0=0x0040, v1=0x1010, v2=0x000F, v3=0x00F0, t0=0x0000, a0=0x0010, a1=0x0005. All other slots reset to 0x0000. Writes are ignored while reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are applied on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd0_cls | input | 2 | Read port 0 class code |
| rd0_idx | input | 2 | Read port 0 index |
| rd0_data | output | 16 | Read port 0 data |
| rd1_cls | input | 2 | Read port 1 class code |
| rd1_idx | input | 2 | Read port 1 index |
| rd1_data | output | 16 | Read port 1 data |
| wr_en | input | 1 | General write enable |
| wr_cls | input | 2 | General write class code |
| wr_idx | input | 2 | General write index |
| wr_data | input | 16 | General write data |
| bl_en | input | 1 | Byte load enable |
| bl_idx | input | 2 | Staging register index for byte load |
| bl_imm | input | 8 | Byte load immediate |
| cmb_en | input | 1 | Combine write-back enable |
| cmb_cls | input | 2 | Combine destination class code |
| cmb_idx | input | 2 | Combine destination index |
| st_word | output | 16 | Combined word {p1[7:0], p0[7:0]} |
| st_addr | output | 16 | Current content of a0 |

## Verification
The assertions check the following on every cycle:

- Reads of t1 return zero, and t1 stays zero.
- Each write source lands in its slot on the next falling edge when no higher-priority source targets the same slot.
- A read of a0 agrees with `st_addr`.

Some behaviour only the bench's reference model can show:

- The old value is returned for a read in the cycle of its write.
- The exact reset contents.
- The masking of the upper staging bytes in the combined word.
- The outcome of colliding writes against an independently computed expectation.
- The combined byte-load/combine sequences that build a full word.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int RB_DW = 16;
  localparam int RB_CW = 2;
  localparam int RB_IW = 2;

  typedef enum logic [1:0] {
    RC_V = 2'b00,
    RC_T = 2'b01,
    RC_A = 2'b10,
    RC_P = 2'b11
  } rclass_e;

  // Starting content of a slot, slot = {class, index}
  function automatic logic [RB_DW-1:0] slot_init(input int slot);
    logic [RB_DW-1:0] v;
    case (slot)
      0:       v = 16'h0040;
      1:       v = 16'h1010;
      2:       v = 16'h000F;
      3:       v = 16'h00F0;
      8:       v = 16'h0010;
      9:       v = 16'h0005;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/regbank_rstsync.sv
module regbank_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  // Flops share the falling edge with the storage so release aligns to it
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q = sync_q[1];
endmodule

// File: rtl/regbank_decode.sv
module regbank_decode #(
  parameter int CW = regbank_pkg::RB_CW,
  parameter int IW = regbank_pkg::RB_IW,
  localparam int AW = CW + IW,
  localparam int NREG = 1 << AW
) (
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_slot,
  input  logic            bl_en,
  input  logic [IW-1:0]   bl_idx,
  input  logic            cmb_en,
  input  logic [AW-1:0]   cmb_slot,
  output logic [NREG-1:0] wr_hit,
  output logic [NREG-1:0] bl_hit,
  output logic [NREG-1:0] cmb_hit
);
  import regbank_pkg::*;

  localparam logic [AW-1:0] ZERO_SLOT = {CW'(RC_T), IW'(1)};

  logic [AW-1:0] bl_slot;

  always_comb begin
    bl_slot = {CW'(RC_P), bl_idx};
  end

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    if (i == int'(ZERO_SLOT)) begin : g_zero
      always_comb begin
        wr_hit[i]  = 1'b0;
        bl_hit[i]  = 1'b0;
        cmb_hit[i] = 1'b0;
      end
    end else begin : g_live
      always_comb begin
        wr_hit[i]  = wr_en  && (wr_slot  == AW'(i));
        bl_hit[i]  = bl_en  && (bl_slot  == AW'(i));
        cmb_hit[i] = cmb_en && (cmb_slot == AW'(i));
      end
    end
  end
endmodule

// File: rtl/regbank_join.sv
module regbank_join #(
  parameter int DW = regbank_pkg::RB_DW,
  localparam int BW = DW / 2
) (
  input  logic [BW-1:0] lo_byte,
  input  logic [BW-1:0] hi_byte,
  output logic [DW-1:0] word
);
  always_comb begin
    word = {hi_byte, lo_byte};
  end
endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
  parameter int DW = regbank_pkg::RB_DW,
  parameter int CW = regbank_pkg::RB_CW,
  parameter int IW = regbank_pkg::RB_IW,
  localparam int AW = CW + IW,
  localparam int NREG = 1 << AW,
  localparam int BW = DW / 2
) (
  input  logic            clk,
  input  logic            rst_q,
  input  logic [NREG-1:0] wr_hit,
  input  logic [NREG-1:0] bl_hit,
  input  logic [NREG-1:0] cmb_hit,
  input  logic [DW-1:0]   wr_data,
  input  logic [BW-1:0]   bl_imm,
  input  logic [DW-1:0]   cmb_word,
  input  logic [AW-1:0]   rd0_slot,
  input  logic [AW-1:0]   rd1_slot,
  output logic [DW-1:0]   rd0_data,
  output logic [DW-1:0]   rd1_data,
  output logic [BW-1:0]   p0_lo,
  output logic [BW-1:0]   p1_lo,
  output logic [DW-1:0]   a0_word
);
  import regbank_pkg::*;

  localparam int ZERO_SLOT = int'({CW'(RC_T), IW'(1)});
  localparam int A0_SLOT   = int'({CW'(RC_A), IW'(0)});
  localparam int P0_SLOT   = int'({CW'(RC_P), IW'(0)});
  localparam int P1_SLOT   = int'({CW'(RC_P), IW'(1)});

  logic [DW-1:0]   mem   [NREG];
  logic [DW-1:0]   mem_d [NREG];
  logic [NREG-1:0] mem_en;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    // Next state: combine over byte load over general write
    always_comb begin
      mem_en[i] = wr_hit[i] || bl_hit[i] || cmb_hit[i];
      if (cmb_hit[i])     mem_d[i] = cmb_word;
      else if (bl_hit[i]) mem_d[i] = {{(DW-BW){1'b0}}, bl_imm};
      else                mem_d[i] = wr_data;
    end

    always_ff @(negedge clk or negedge rst_q) begin
      if (!rst_q)         mem[i] <= slot_init(i);
      else if (mem_en[i]) mem[i] <= mem_d[i];
    end

    // R9
    cmb_land_chk: assert property (@(negedge clk) disable iff (!rst_q)
      cmb_hit[i] |=> (mem[i] == $past(cmb_word)));

    // R7
    bl_land_chk: assert property (@(negedge clk) disable iff (!rst_q)
      (bl_hit[i] && !cmb_hit[i]) |=> (mem[i] == {{(DW-BW){1'b0}}, $past(bl_imm)}));

    // R5
    wr_land_chk: assert property (@(negedge clk) disable iff (!rst_q)
      (wr_hit[i] && !bl_hit[i] && !cmb_hit[i]) |=> (mem[i] == $past(wr_data)));
  end

  always_comb begin
    rd0_data = (int'(rd0_slot) == ZERO_SLOT) ? '0 : mem[rd0_slot];
    rd1_data = (int'(rd1_slot) == ZERO_SLOT) ? '0 : mem[rd1_slot];
    p0_lo    = mem[P0_SLOT][BW-1:0];
    p1_lo    = mem[P1_SLOT][BW-1:0];
    a0_word  = mem[A0_SLOT];
  end

  // R4
  zero_hold_chk: assert property (@(negedge clk) disable iff (!rst_q)
    (wr_hit[ZERO_SLOT] || !wr_hit[ZERO_SLOT]) |=> (mem[ZERO_SLOT] == '0));
endmodule

// File: rtl/regbank_top.sv
module regbank_top #(
  parameter int DW = regbank_pkg::RB_DW,
  parameter int CW = regbank_pkg::RB_CW,
  parameter int IW = regbank_pkg::RB_IW,
  localparam int AW = CW + IW,
  localparam int NREG = 1 << AW,
  localparam int BW = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rd0_cls,
  input  logic [IW-1:0] rd0_idx,
  output logic [DW-1:0] rd0_data,
  input  logic [CW-1:0] rd1_cls,
  input  logic [IW-1:0] rd1_idx,
  output logic [DW-1:0] rd1_data,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_cls,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          bl_en,
  input  logic [IW-1:0] bl_idx,
  input  logic [BW-1:0] bl_imm,
  input  logic          cmb_en,
  input  logic [CW-1:0] cmb_cls,
  input  logic [IW-1:0] cmb_idx,
  output logic [DW-1:0] st_word,
  output logic [DW-1:0] st_addr
);
  import regbank_pkg::*;

  localparam logic [AW-1:0] ZERO_SLOT = {CW'(RC_T), IW'(1)};
  localparam logic [AW-1:0] A0_SLOT   = {CW'(RC_A), IW'(0)};

  logic            rst_q;
  logic [NREG-1:0] wr_hit;
  logic [NREG-1:0] bl_hit;
  logic [NREG-1:0] cmb_hit;
  logic [BW-1:0]   p0_lo;
  logic [BW-1:0]   p1_lo;
  logic [DW-1:0]   cmb_word;
  logic [DW-1:0]   a0_word;
  logic [AW-1:0]   rd0_slot;
  logic [AW-1:0]   rd1_slot;
  logic [AW-1:0]   wr_slot;
  logic [AW-1:0]   cmb_slot;
  logic            wr_go;
  logic            bl_go;
  logic            cmb_go;

  always_comb begin
    rd0_slot = {rd0_cls, rd0_idx};
    rd1_slot = {rd1_cls, rd1_idx};
    wr_slot  = {wr_cls, wr_idx};
    cmb_slot = {cmb_cls, cmb_idx};
    wr_go    = wr_en  && rst_q;
    bl_go    = bl_en  && rst_q;
    cmb_go   = cmb_en && rst_q;
  end

  regbank_rstsync u_rstsync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  regbank_decode #(.CW(CW), .IW(IW)) u_decode (
    .wr_en    (wr_go),
    .wr_slot  (wr_slot),
    .bl_en    (bl_go),
    .bl_idx   (bl_idx),
    .cmb_en   (cmb_go),
    .cmb_slot (cmb_slot),
    .wr_hit   (wr_hit),
    .bl_hit   (bl_hit),
    .cmb_hit  (cmb_hit)
  );

  regbank_join #(.DW(DW)) u_join (
    .lo_byte (p0_lo),
    .hi_byte (p1_lo),
    .word    (cmb_word)
  );

  regbank_store #(.DW(DW), .CW(CW), .IW(IW)) u_store (
    .clk      (clk),
    .rst_q    (rst_q),
    .wr_hit   (wr_hit),
    .bl_hit   (bl_hit),
    .cmb_hit  (cmb_hit),
    .wr_data  (wr_data),
    .bl_imm   (bl_imm),
    .cmb_word (cmb_word),
    .rd0_slot (rd0_slot),
    .rd1_slot (rd1_slot),
    .rd0_data (rd0_data),
    .rd1_data (rd1_data),
    .p0_lo    (p0_lo),
    .p1_lo    (p1_lo),
    .a0_word  (a0_word)
  );

  always_comb begin
    st_word = cmb_word;
    st_addr = a0_word;
  end

  // R3
  zero_rd0_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rd0_slot == ZERO_SLOT) |-> (rd0_data == '0));

  // R3
  zero_rd1_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rd1_slot == ZERO_SLOT) |-> (rd1_data == '0));

  // R10
  st_addr_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rd0_slot == A0_SLOT) |-> (rd0_data == st_addr));
endmodule

// File: tb/test_regbank_top.sv
module test_regbank_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rd0_cls = '0, rd0_idx = '0, rd1_cls = '0, rd1_idx = '0;
  logic [15:0] rd0_data, rd1_data, st_word, st_addr;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_cls = '0, wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic        bl_en = 1'b0;
  logic [1:0]  bl_idx = '0;
  logic [7:0]  bl_imm = '0;
  logic        cmb_en = 1'b0;
  logic [1:0]  cmb_cls = '0, cmb_idx = '0;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] m [16];

  always #4 clk = ~clk;

  regbank_top i_regbank_top (
    .clk(clk), .rst_n(rst_n),
    .rd0_cls(rd0_cls), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
    .rd1_cls(rd1_cls), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_cls(wr_cls), .wr_idx(wr_idx), .wr_data(wr_data),
    .bl_en(bl_en), .bl_idx(bl_idx), .bl_imm(bl_imm),
    .cmb_en(cmb_en), .cmb_cls(cmb_cls), .cmb_idx(cmb_idx),
    .st_word(st_word), .st_addr(st_addr)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model_rd(input int s);
    return (s == 5) ? 16'h0000 : m[s];
  endfunction

  // One cycle: drive after rising edge, compare before falling edge, then
  // advance the model at the falling edge.
  task automatic step(input string tag, input int r0, input int r1,
                      input bit we, input int wa, input logic [15:0] wd,
                      input bit be, input int bi, input logic [7:0] bv,
                      input bit ce, input int ca);
    logic [15:0] joined;
    {rd0_cls, rd0_idx} = 4'(r0);
    {rd1_cls, rd1_idx} = 4'(r1);
    wr_en = we; {wr_cls, wr_idx} = 4'(wa); wr_data = wd;
    bl_en = be; bl_idx = 2'(bi); bl_imm = bv;
    cmb_en = ce; {cmb_cls, cmb_idx} = 4'(ca);
    #2;
    joined = {m[13][7:0], m[12][7:0]};
    check(tag, "rd0", rd0_data, model_rd(r0));
    check(tag, "rd1", rd1_data, model_rd(r1));
    check("R8", "st_word", st_word, joined);
    check("R10", "st_addr", st_addr, m[8]);
    @(negedge clk);
    if (we) m[wa] = wd;
    if (be) m[12 + bi] = {8'h00, bv};
    if (ce) m[ca] = joined;
    m[5] = 16'h0000;
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    for (int i = 0; i < 16; i++) m[i] = 16'h0000;
    m[0] = 16'h0040; m[1] = 16'h1010; m[2] = 16'h000F; m[3] = 16'h00F0;
    m[8] = 16'h0010; m[9] = 16'h0005;
    // R12: writes during reset are ignored
    repeat (2) @(posedge clk);
    #1;
    wr_en = 1'b1; {wr_cls, wr_idx} = 4'd0; wr_data = 16'hDEAD;
    @(posedge clk); #1;
    wr_en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R12 / R1 / R2: reset contents through both ports
    for (int s = 0; s < 16; s++) step("R12", s, 15 - s, 0, 0, 0, 0, 0, 0, 0, 0);
    // R5 / R6: write then same-cycle read returns old value
    step("R6", 2, 9, 1, 2, 16'hA5A5, 0, 0, 0, 0, 0);
    step("R5", 2, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 8, 8, 1, 8, 16'h0200, 0, 0, 0, 0, 0);
    step("R10", 8, 4, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3 / R4: writes to t1 ignored
    step("R4", 5, 5, 1, 5, 16'hFFFF, 0, 0, 0, 0, 0);
    step("R3", 5, 4, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7 / R9: build 0x0001 in p0 from two byte loads
    step("R7", 12, 13, 0, 0, 0, 1, 0, 8'h01, 0, 0);
    step("R7", 12, 13, 0, 0, 0, 1, 1, 8'h00, 0, 0);
    step("R9", 12, 13, 0, 0, 0, 0, 0, 0, 1, 12);
    step("R9", 12, 4, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8: upper bytes of staging registers masked
    step("R8", 12, 13, 1, 12, 16'hABCD, 0, 0, 0, 0, 0);
    step("R8", 12, 13, 1, 13, 16'h1234, 0, 0, 0, 0, 0);
    step("R9", 13, 1, 0, 0, 0, 0, 0, 0, 1, 1);
    step("R9", 1, 12, 0, 0, 0, 0, 0, 0, 0, 0);
    // R4: combine into t1 ignored
    step("R4", 5, 12, 0, 0, 0, 0, 0, 0, 1, 5);
    step("R3", 5, 5, 0, 0, 0, 0, 0, 0, 0, 0);
    // R11: collisions
    step("R11", 12, 13, 1, 12, 16'h7777, 1, 0, 8'h55, 1, 12);
    step("R11", 12, 13, 1, 13, 16'h8888, 1, 1, 8'h66, 0, 0);
    step("R11", 12, 13, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R11", 3, 13, 1, 3, 16'h9999, 0, 0, 0, 1, 3);
    step("R11", 3, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    // R1 / R2 / R5 / R7 / R9 / R11: mixed traffic
    for (int k = 0; k < 400; k++) begin
      int rr;
      rr = int'($urandom);
      step("R2", int'($urandom_range(15)), int'($urandom_range(15)),
           rr[0], int'($urandom_range(15)), 16'($urandom),
           rr[1] & rr[2], int'($urandom_range(3)), 8'($urandom),
           rr[3] & rr[4], int'($urandom_range(15)));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule